// File: doc/BRIEF.md
# I2C Controller Interrupt Vector Encoder

This block sits beside an I2C bus engine and turns its one-cycle event pulses into sticky pending flags. A mask register selects which flags may interrupt. The block drives one interrupt line. It also offers a vector code that names the most urgent enabled event. Software services an interrupt by reading the vector. That read returns the code and clears the one flag it names, so repeated reads walk through the pending events in priority order. Software can also clear the access-ready and stop-detected flags by writing ones to the status register. Two live level inputs, bus busy and receive-shift full, are shown in the status word.

The register port is a plain control port and has no valid/ready handshake. A write takes effect at the clock edge where `reg_wr` is high. Read data is combinational and depends only on `reg_addr`. The `reg_rd` strobe only tells the block that a read is being consumed, which matters for the vector register. The port never applies back-pressure.

Register addresses are: 0 mask, 1 status, 2 vector. Address 3 reads as zero, and writes to it are ignored.

Top module: `i2c_irq_vector`

## Requirements
- R1: A pulse on `evt_pulse[i]` sets pending flag i, whatever the mask holds. The flag is visible at status bit i from the next cycle. The event index map is: 0 arbitration lost, 1 NACK, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R2: The mask register sits at address 0. Bits 6:0 use the same index map, are written by `reg_wr`, and read back unchanged.
- R3: The vector register at address 2 holds 1 + the lowest index whose pending flag and mask bit are both set. This gives codes 1 arbitration lost through 7 addressed as slave, so the lowest code wins. The vector is 0 when no enabled event is pending.
- R4: `irq` is high exactly when some pending flag has its mask bit set.
- R5: A vector read (`reg_rd` with address 2) clears only the flag whose code it returned. A vector read that returns 0 clears nothing.
- R6: Writing 1 to status bit 2 or bit 5 clears that flag. Ones written to status bits 0, 1, 3, 4 and 6 have no effect.
- R7: An event that arrives in the same cycle as a clear of its flag wins. This holds for both a status write and a vector read, and the flag stays pending.
- R8: Status bit 11 shows `rx_shift_full` and bit 12 shows `bus_busy`, both live. These bits cannot be cleared and never produce a vector or an interrupt.
- R9: After reset the pending flags and the mask are zero, the vector reads 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | 7 | One-cycle event pulses, indexed as in R1 |
| bus_busy | input | 1 | Live bus-busy level |
| rx_shift_full | input | 1 | Live receive-shift-full level |
| reg_addr | input | 2 | Register select: 0 mask, 1 status, 2 vector |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read-consume strobe (clears on the vector register) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks that priority follows the lowest enabled index even when a more urgent event is masked off. An encoder that scanned from the top, or ignored the mask, would report the wrong code. It drains several pending events with successive vector reads and expects codes in ascending order, then zero. A design that cleared every enabled flag on one read, or cleared nothing, would show a short or endless sequence. It aims an event at the exact cycle of its own clear, for both kinds of clear; a design that let the clear win would lose that event. It also writes all ones to the status register and confirms that only the two write-clearable flags fall, and that the bus level bits never raise `irq`.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  typedef enum logic [1:0] {
    ADR_MASK = 2'd0,
    ADR_STAT = 2'd1,
    ADR_VEC  = 2'd2,
    ADR_NONE = 2'd3
  } irqv_addr_e;
endpackage

// File: rtl/irqv_flags.sv
module irqv_flags #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  // set after clear: an event in the same cycle as its clear survives
  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  // R1 / R7: every pulsed event is pending the next cycle, clear or not
  a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

  // R5: a flag only falls when a clear was requested for it
  a_r5_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~pend_o & $past(pend_o) & ~$past(clr_i)) == '0));

  // R1: a flag only rises because of an event pulse
  a_r1_rise_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(set_i)) == '0));
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int N  = 7,
  parameter int CW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  grant_o
);
  // scan from the top so the lowest index is assigned last and wins
  always_comb begin
    code_o  = '0;
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        code_o     = CW'(i + 1);
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
  import irqv_pkg::*;
#(
  parameter int              NUM_EVT  = 7,
  parameter int              DATA_W   = 16,
  parameter int              RSF_POS  = 11,
  parameter int              BUSY_POS = 12,
  parameter logic [NUM_EVT-1:0] W1C_SEL = 7'b0100100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        evt_pulse,
  input  logic              bus_busy,
  input  logic              rx_shift_full,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CW = $clog2(NUM_EVT + 1);

  irqv_addr_e   addr;
  logic [NUM_EVT-1:0] mask_q, pend, enabled, grant, clr;
  logic [CW-1:0]      code;
  logic               vec_rd, stat_wr, mask_wr;
  logic               unused_wbits;

  assign addr    = irqv_addr_e'(reg_addr);
  assign vec_rd  = reg_rd && (addr == ADR_VEC);
  assign stat_wr = reg_wr && (addr == ADR_STAT);
  assign mask_wr = reg_wr && (addr == ADR_MASK);
  assign unused_wbits = ^reg_wdata[DATA_W-1:NUM_EVT];

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= reg_wdata[NUM_EVT-1:0];
  end

  assign clr = (vec_rd  ? grant : '0)
             | (stat_wr ? (reg_wdata[NUM_EVT-1:0] & W1C_SEL) : '0);

  irqv_flags #(.N(NUM_EVT)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (evt_pulse),
    .clr_i  (clr),
    .pend_o (pend)
  );

  assign enabled = pend & mask_q;

  irqv_prio #(.N(NUM_EVT), .CW(CW)) u_prio (
    .req_i   (enabled),
    .code_o  (code),
    .grant_o (grant)
  );

  assign irq = |enabled;

  always_comb begin
    reg_rdata = '0;
    unique case (addr)
      ADR_MASK: reg_rdata[NUM_EVT-1:0] = mask_q;
      ADR_STAT: begin
        reg_rdata[NUM_EVT-1:0] = pend;
        reg_rdata[RSF_POS]     = rx_shift_full;
        reg_rdata[BUSY_POS]    = bus_busy;
      end
      ADR_VEC:  reg_rdata[CW-1:0] = code;
      default:  reg_rdata = '0;
    endcase
  end

  // R4: the interrupt line agrees with the encoder's verdict
  a_r4_irq_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (code != '0));

  // R3: the granted flag is a single enabled flag
  a_r3_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((grant & ~enabled) == '0));

  // R5: a vector read removes the reported flag unless an event refills it
  a_r5_read_clears_reported: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd && code != '0 && ((evt_pulse & grant) == '0))
      |=> ((pend & $past(grant)) == '0));

  // R6: status writes never drop flags outside the write-clearable set
  a_r6_protected_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !vec_rd) |=> ((pend & ~W1C_SEL) == ($past(pend) & ~W1C_SEL) | ($past(evt_pulse) & ~W1C_SEL)));

  // R9: state is cleared the cycle after reset
  a_r9_reset_clean: assert property (@(posedge clk)
    !rst_n |=> (pend == '0 && mask_q == '0));
endmodule

// File: tb/i2c_irq_vector_bench.sv
module i2c_irq_vector_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  evt_pulse = '0;
  logic        bus_busy = 1'b0;
  logic        rx_shift_full = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  i2c_irq_vector u_i2c_irq_vector (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .bus_busy(bus_busy),
    .rx_shift_full(rx_shift_full), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {mask[6:0], events[6:0], expected code[2:0]}
  localparam logic [16:0] TBL [8] = '{
    {7'h7F, 7'h7F, 3'd1},
    {7'h7F, 7'h60, 3'd6},
    {7'h1C, 7'h13, 3'd5},
    {7'h00, 7'h7F, 3'd0},
    {7'h40, 7'h40, 3'd7},
    {7'h7E, 7'h09, 3'd4},
    {7'h06, 7'h04, 3'd3},
    {7'h02, 7'h03, 3'd2}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic pulse(input logic [6:0] e);
    @(negedge clk); evt_pulse = e;
    @(negedge clk); evt_pulse = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd_vec(output logic [15:0] v);
    @(negedge clk); reg_addr = 2'd2; reg_rd = 1'b1; #1; v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  initial begin
    #3000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] v;
    do_reset();
    // R9: reset state
    @(negedge clk);
    peek(2'd0, v); check("R9 mask after reset", v, 16'h0000);
    peek(2'd1, v); check("R9 status after reset", v, 16'h0000);
    peek(2'd2, v); check("R9 vector after reset", v, 16'h0000);
    check("R9 irq after reset", {15'd0, irq}, 16'h0000);

    // table walk: R1, R2, R3, R4
    foreach (TBL[k]) begin
      do_reset();
      wr(2'd0, {9'd0, TBL[k][16:10]});
      pulse(TBL[k][9:3]);
      peek(2'd0, v); check("R2 mask readback", v, {9'd0, TBL[k][16:10]});
      peek(2'd1, v); check("R1 status flags", v, {9'd0, TBL[k][9:3]});
      peek(2'd2, v); check("R3 vector code", v, {13'd0, TBL[k][2:0]});
      check("R4 irq level", {15'd0, irq}, {15'd0, TBL[k][2:0] != 3'd0});
    end

    // R5: drain by successive vector reads
    do_reset();
    wr(2'd0, 16'h007F);
    pulse(7'h25);
    rd_vec(v); check("R5 first read code", v, 16'd1);
    rd_vec(v); check("R5 second read code", v, 16'd3);
    rd_vec(v); check("R5 third read code", v, 16'd6);
    peek(2'd2, v); check("R5 drained vector", v, 16'd0);
    peek(2'd1, v); check("R5 drained status", v, 16'h0000);
    check("R5 irq after drain", {15'd0, irq}, 16'h0000);

    // R5: a read returning 0 clears nothing
    do_reset();
    pulse(7'h12);
    rd_vec(v); check("R5 zero-code read", v, 16'd0);
    peek(2'd1, v); check("R5 zero read keeps flags", v, 16'h0012);

    // R6: write-one-to-clear only on bits 2 and 5
    do_reset();
    pulse(7'h7F);
    wr(2'd1, 16'hFFFF);
    peek(2'd1, v); check("R6 only bits 2 and 5 cleared", v, 16'h005B);

    // R7: event coincides with status write clear
    do_reset();
    pulse(7'h04);
    @(negedge clk); reg_addr = 2'd1; reg_wdata = 16'h0004; reg_wr = 1'b1; evt_pulse = 7'h04;
    @(negedge clk); reg_wr = 1'b0; evt_pulse = '0;
    peek(2'd1, v); check("R7 event beats status clear", v, 16'h0004);

    // R7: event coincides with vector read clear
    do_reset();
    wr(2'd0, 16'h007F);
    pulse(7'h01);
    @(negedge clk); reg_addr = 2'd2; reg_rd = 1'b1; evt_pulse = 7'h01;
    @(negedge clk); reg_rd = 1'b0; evt_pulse = '0;
    peek(2'd1, v); check("R7 event beats vector clear", v, 16'h0001);
    peek(2'd2, v); check("R7 vector still reports", v, 16'd1);

    // R8: level bits are live, not clearable, raise nothing
    do_reset();
    wr(2'd0, 16'h007F);
    @(negedge clk); bus_busy = 1'b1; rx_shift_full = 1'b1;
    wr(2'd1, 16'hFFFF);
    peek(2'd1, v); check("R8 level bits shown", v, 16'h1800);
    peek(2'd2, v); check("R8 no vector from levels", v, 16'd0);
    check("R8 no irq from levels", {15'd0, irq}, 16'h0000);
    @(negedge clk); bus_busy = 1'b0;
    peek(2'd1, v); check("R8 busy follows input", v, 16'h0800);
    rx_shift_full = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule